// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a small 32-bit RISC core and picks its next value every clock cycle. The fetch stage presents the instruction word it has just read, and the register file presents the values of the two source registers that the word names (the first source register, selected by bits 25:21, and the second, selected by bits 20:16). From these the unit chooses one of four candidates. The first is the sequential address, which is the PC plus 4. The second is a PC-relative branch target. The third is a jump target formed by splicing the instruction's 26-bit field under the top PC bits. The fourth is a target read from a register. The chosen candidate is loaded into the PC at the next edge.

The covered control transfers are the unconditional jump, the register jump, branch-if-equal, branch-if-not-equal and branch-if-negative. Every other word advances the PC by one instruction. A `taken_o` flag is combinational on the current inputs and reports whether this cycle's word redirects the flow.

A synchronous reset loads a fixed address. A stall input freezes the PC so that an upstream hazard can hold fetch. The pins are plain control and data with no handshake: the core presents one instruction per non-stalled cycle, and `stall` is the only form of back-pressure.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_o` equals `RESET_ADDR` (default 0x00000000) after that edge.
- R2: An instruction that is none of the control transfers listed in R3 to R7 sets the PC to PC+4 at the next unstalled edge, with `taken_o` low.
- R3: Opcode 4 in bits 31:26 compares the two register values. If they are equal, `taken_o` is high and the PC becomes PC+4 plus the sign-extended bits 15:0 shifted left by two. Otherwise `taken_o` is low and the PC becomes PC+4.
- R4: Opcode 5 behaves like R3, except that the branch is taken when the two register values differ.
- R5: Opcode 1 with bits 20:16 equal to zero is taken exactly when bit 31 of the first register value is 1, and it uses the target of R3. Opcode 1 with a non-zero value in bits 20:16 is treated as in R2.
- R6: Opcode 2 is always taken. The PC becomes the top four bits of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R7: Opcode 0 with function bits 5:0 equal to 8 is always taken, and the PC becomes the full first register value. Opcode 0 with any other function code is treated as in R2.
- R8: While `stall` is high and `rst` is low, the PC keeps its value whatever the instruction is. `taken_o` still reports the decode of the current inputs.
- R9: Reset takes priority over stall.
- R10: All address arithmetic wraps modulo 2^32. This covers a negative branch offset and an increment from 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC when high |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | XLEN | Value of the first source register (bits 25:21) |
| rt_val | input | XLEN | Value of the second source register (bits 20:16) |
| pc_o | output | XLEN | Current program counter |
| taken_o | output | 1 | High when the current word redirects the flow |

## Verification
A wrong decode appears on `taken_o` in the same cycle that the instruction is presented. A wrong target, a missed stall or a missed reset appears on `pc_o` one edge later. A PC error persists: every later sequential and branch address is computed from the corrupted PC. The bench therefore checks `taken_o` shortly after each input change and checks `pc_o` after every edge. A single bad edge cannot be masked by later steps.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned OFS_W   = 16;
  localparam int unsigned JIDX_W  = 26;
  localparam int unsigned SEG_W   = 4;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_REGIMM  = 6'd1;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_BEQ     = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE     = 6'd5;
  localparam logic [FN_W-1:0]  FN_JREG     = 6'd8;

  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2,
    NXT_REG    = 2'd3
  } nxt_sel_e;

  typedef struct packed {
    nxt_sel_e sel;
    logic     taken;
  } nxt_dec_t;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [REG_W-1:0] rt_idx,
  input  logic [FN_W-1:0]  fn,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output nxt_dec_t         dec
);
  logic regs_eq;
  logic rs_neg;

  assign regs_eq = (rs_val == rt_val);
  assign rs_neg  = rs_val[XLEN-1];

  always_comb begin
    dec.sel   = NXT_SEQ;
    dec.taken = 1'b0;
    unique case (opc)
      OPC_JUMP: begin
        dec.sel   = NXT_JUMP;
        dec.taken = 1'b1;
      end
      OPC_SPECIAL: begin
        if (fn == FN_JREG) begin
          dec.sel   = NXT_REG;
          dec.taken = 1'b1;
        end
      end
      OPC_BEQ: begin
        if (regs_eq) begin
          dec.sel   = NXT_BRANCH;
          dec.taken = 1'b1;
        end
      end
      OPC_BNE: begin
        if (!regs_eq) begin
          dec.sel   = NXT_BRANCH;
          dec.taken = 1'b1;
        end
      end
      OPC_REGIMM: begin
        if (rt_idx == '0 && rs_neg) begin
          dec.sel   = NXT_BRANCH;
          dec.taken = 1'b1;
        end
      end
      default: begin
        dec.sel   = NXT_SEQ;
        dec.taken = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pcu_targets.sv
module pcu_targets
  import pcu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [JIDX_W-1:0] jfield,
  output logic [XLEN-1:0]   seq_addr,
  output logic [XLEN-1:0]   br_addr,
  output logic [XLEN-1:0]   jmp_addr
);
  localparam int unsigned EXT_W = XLEN - OFS_W - 2;

  logic [OFS_W-1:0] ofs;
  logic [XLEN-1:0]  ofs_bytes;

  assign ofs       = jfield[OFS_W-1:0];
  assign seq_addr  = pc + XLEN'(4);
  assign ofs_bytes = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
  assign br_addr   = seq_addr + ofs_bytes;
  assign jmp_addr  = {seq_addr[XLEN-1 -: SEG_W], jfield, 2'b00};
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int unsigned    XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    rs_val,
  input  logic [XLEN-1:0]    rt_val,
  output logic [XLEN-1:0]    pc_o,
  output logic               taken_o
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_addr, br_addr, jmp_addr, nxt_addr;
  nxt_dec_t        dec;

  pcu_decode #(.XLEN(XLEN)) u_decode (
    .opc    (instr[31:26]),
    .rt_idx (instr[20:16]),
    .fn     (instr[5:0]),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .dec    (dec)
  );

  pcu_targets #(.XLEN(XLEN)) u_targets (
    .pc       (pc_q),
    .jfield   (instr[JIDX_W-1:0]),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr)
  );

  always_comb begin
    unique case (dec.sel)
      NXT_BRANCH: nxt_addr = br_addr;
      NXT_JUMP:   nxt_addr = jmp_addr;
      NXT_REG:    nxt_addr = rs_val;
      default:    nxt_addr = seq_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= RESET_ADDR;
    else if (!stall) pc_q <= nxt_addr;
  end

  assign pc_o    = pc_q;
  assign taken_o = dec.taken;
endmodule

// File: rtl/pc_next_chk.sv
module pc_next_chk #(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic [XLEN-1:0] pc_o,
  input logic            taken_o
);
  logic            rst_seen = 1'b0;
  logic [XLEN-1:0] pc_inc;
  logic            is_jr, is_j, is_beq, is_bltz;

  assign pc_inc  = pc_o + XLEN'(4);
  assign is_jr   = (instr[31:26] == 6'd0) && (instr[5:0] == 6'd8);
  assign is_j    = (instr[31:26] == 6'd2);
  assign is_beq  = (instr[31:26] == 6'd4);
  assign is_bltz = (instr[31:26] == 6'd1) && (instr[20:16] == 5'd0);

  // R1, R9: PC equals the reset address after every reset edge
  always @(posedge clk) begin
    if (rst_seen) begin
      p_reset_load_r1: assert (pc_o == RESET_ADDR);
    end
    rst_seen <= rst;
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc_o));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall && !taken_o) |=> (pc_o == $past(pc_inc)));

  p_jreg_taken_r7: assert property (@(posedge clk) disable iff (rst)
    is_jr |-> taken_o);

  p_jreg_load_r7: assert property (@(posedge clk) disable iff (rst)
    (!stall && is_jr) |=> (pc_o == $past(rs_val)));

  p_jump_splice_r6: assert property (@(posedge clk) disable iff (rst)
    (!stall && is_j) |=> (pc_o == {$past(pc_inc[XLEN-1:XLEN-4]), $past(instr[25:0]), 2'b00}));

  p_beq_cond_r3: assert property (@(posedge clk) disable iff (rst)
    is_beq |-> (taken_o == (rs_val == rt_val)));

  p_bltz_cond_r5: assert property (@(posedge clk) disable iff (rst)
    is_bltz |-> (taken_o == rs_val[XLEN-1]));
endmodule

bind pc_next_unit pc_next_chk #(.XLEN(XLEN), .RESET_ADDR(RESET_ADDR)) u_chk (.*);

// File: tb/tb_pc_next_unit.sv
`timescale 1ns/100ps
module tb_pc_next_unit;
  logic        clk = 1'b0;
  logic        rst, stall;
  logic [31:0] instr, rs_val, rt_val;
  logic [31:0] pc_o;
  logic        taken_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] exp_pc = 32'h0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  pc_next_unit dut (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc_o(pc_o), .taken_o(taken_o)
  );

  function automatic bit m_taken(logic [31:0] i, logic [31:0] a, logic [31:0] b);
    case (i[31:26])
      6'd2: return 1'b1;
      6'd0: return i[5:0] == 6'd8;
      6'd4: return a == b;
      6'd5: return a != b;
      6'd1: return (i[20:16] == 5'd0) && a[31];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_next(logic [31:0] pc, logic [31:0] i,
                                         logic [31:0] a, logic [31:0] b);
    logic [31:0] inc;
    inc = pc + 32'd4;
    if (!m_taken(i, a, b)) return inc;
    case (i[31:26])
      6'd2: return {inc[31:28], i[25:0], 2'b00};
      6'd0: return a;
      default: return inc + {{14{i[15]}}, i[15:0], 2'b00};
    endcase
  endfunction

  function automatic string m_req(logic [31:0] i);
    case (i[31:26])
      6'd0: return (i[5:0] == 6'd8) ? "R7" : "R7/R2";
      6'd1: return "R5";
      6'd2: return "R6";
      6'd4: return "R3";
      6'd5: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic step(logic [31:0] i, logic [31:0] a, logic [31:0] b,
                      bit st, bit r, string tag = "");
    string req;
    instr = i; rs_val = a; rt_val = b; stall = st; rst = r;
    #1;
    req = (tag != "") ? tag : m_req(i);
    if (!r) check({req, " taken"}, {31'd0, taken_o}, {31'd0, m_taken(i, a, b)});
    @(posedge clk);
    if (r)       exp_pc = 32'h0;
    else if (!st) exp_pc = m_next(exp_pc, i, a, b);
    @(negedge clk);
    if (r)       req = "R1";
    else if (st) req = "R8";
    check({req, " pc"}, pc_o, exp_pc);
  endtask

  function automatic logic [31:0] rnd_instr();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: return {6'd0, r[25:6], ($urandom % 2) ? 6'd8 : r[5:0]};
      1: return {6'd1, r[25:21], ($urandom % 2) ? 5'd0 : r[20:16], r[15:0]};
      2: return {6'd2, r[25:0]};
      3: return {6'd4, r[25:0]};
      4: return {6'd5, r[25:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    instr = 32'h0; rs_val = 32'h0; rt_val = 32'h0; stall = 1'b0; rst = 1'b1;
    @(negedge clk);
    // R1: reset state
    step(32'h0, 32'h0, 32'h0, 1'b0, 1'b1, "R1");
    // R2: plain arithmetic word
    step(32'h0232_4020, 32'h1, 32'h2, 1'b0, 1'b0, "R2");
    // R3: beq equal, forward offset
    step({6'd4, 5'd1, 5'd2, 16'h0010}, 32'h55, 32'h55, 1'b0, 1'b0, "R3");
    // R3: beq unequal
    step({6'd4, 5'd1, 5'd2, 16'h0010}, 32'h55, 32'h56, 1'b0, 1'b0, "R3");
    // R4 and R10: bne differs with a negative offset
    step({6'd5, 5'd1, 5'd2, 16'hFFF0}, 32'h1, 32'h2, 1'b0, 1'b0, "R4");
    step({6'd5, 5'd1, 5'd2, 16'hFFF0}, 32'h7, 32'h7, 1'b0, 1'b0, "R4");
    // R5: bltz negative, non-negative, and non-zero rt field
    step({6'd1, 5'd3, 5'd0, 16'h0004}, 32'h8000_0000, 32'h0, 1'b0, 1'b0, "R5");
    step({6'd1, 5'd3, 5'd0, 16'h0004}, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b0, "R5");
    step({6'd1, 5'd3, 5'd1, 16'h0004}, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, "R5");
    // R7: jr, then another function code under opcode 0
    step({6'd0, 5'd31, 15'd0, 6'd8}, 32'hFFFF_FFFC, 32'h0, 1'b0, 1'b0, "R7");
    // R10: increment wraps to zero
    step(32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R10");
    step({6'd0, 5'd31, 15'd0, 6'd8}, 32'hEFFF_FFFC, 32'h0, 1'b0, 1'b0, "R7");
    // R6: segment bits from PC+4 (0xF0000000)
    step({6'd2, 26'h000_1234}, 32'h0, 32'h0, 1'b0, 1'b0, "R6");
    // R8: a jump under stall leaves the PC unchanged
    step({6'd2, 26'h3FF_FFFF}, 32'h0, 32'h0, 1'b1, 1'b0, "R8");
    // R9: reset wins over stall
    step({6'd2, 26'h3FF_FFFF}, 32'h0, 32'h0, 1'b1, 1'b1, "R9");
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] i, a, b;
      i = rnd_instr();
      a = $urandom;
      if ($urandom % 4 == 0) a[31] = 1'b1;
      b = ($urandom % 3 == 0) ? a : $urandom;
      step(i, a, b, ($urandom % 8) == 0, ($urandom % 128) == 0);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule